// File: doc/BRIEF.md
# Instruction Fetch and Length Decoder

This block fetches one instruction at a time from a byte-wide program memory and hands it to the rest of the core as a complete, decoded unit. It reads the opcode at the program counter. From that byte alone it works out whether the instruction is one, two or three bytes long. It then reads the operand bytes that follow.

When the last byte arrives, it presents the following for one cycle, marked by a valid strobe:
- the opcode and the address it was fetched from;
- the length;
- the register, register-pair and condition fields;
- a few classification flags;
- the operands, packed as an 8-bit immediate and as a 16-bit little-endian immediate.

Fetching runs continuously. The next opcode is requested straight after the last byte of the previous instruction. A load input redirects the program counter for jumps, calls and returns. A load takes effect at once and discards any partly fetched instruction. Memory reads use a request/ready handshake, so program memory may insert any number of wait cycles.

Top module: `opfetch_unit`

## Requirements
- R1: While `rst` is high, and on the first clock edge with `rst` high, `mem_req` and `ins_valid` go low. `mem_addr` takes `RESET_PC` (default 0) and every `ins_*` output is cleared to zero. In the first cycle after reset is released, `mem_req` is high with `mem_addr` still at `RESET_PC`.
- R2: A byte is taken from `mem_rdata` only at a clock edge where `mem_req` and `mem_ready` are both high and `pc_load` is low. While `mem_ready` stays low, `mem_req` stays high, `mem_addr` holds, and no instruction completes.
- R3: Every opcode in the following list is three bytes long; `ins_len` = 3:
  - pattern 00pp0001;
  - 0x22, 0x2A, 0x32, 0x3A;
  - the jump codes 0xC3 and 0xCB;
  - pattern 11xx1101 (0xCD, 0xDD, 0xED, 0xFD);
  - pattern 11ccc010;
  - pattern 11ccc100.
- R4: Every opcode in the following list is two bytes long; `ins_len` = 2:
  - pattern 00ddd110;
  - pattern 11ooo110;
  - 0xD3 and 0xDB.
- R5: Every other opcode is one byte long (`ins_len` = 1). This includes 0x76, the unused codes 0x08, 0x10, 0x18, 0x20, 0x28, 0x30 and 0x38, and 0xD9.
- R6: `ins_imm8` is the byte after the opcode and `ins_imm16` is {third byte, second byte}. Bytes beyond the instruction's length read as zero: a one-byte instruction gives 0 on both, and a two-byte one gives `ins_imm16` = {8'h00, `ins_imm8`}.
- R7: Field positions are as follows:
  - `ins_dst` and `ins_cond` are opcode bits 5:3;
  - `ins_src` is bits 2:0;
  - `ins_pair` is bits 5:4.

  Register codes are 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory through HL and 7=A.
- R8: `ins_pair` codes are 0=BC, 1=DE, 2=HL and 3=SP. `ins_psw` is high only for 0xF1 and 0xF5 (pattern 11pp0p01 with pair 3), where pair 3 names the accumulator-and-flags word instead of SP.
- R9: `ins_halt` is high only for 0x76. `ins_mem_hl` is high for each of these opcode groups:
  - 01ddd110 and 01110sss, except 0x76;
  - 10ooo110;
  - 0x34, 0x35, 0x36.

  `ins_mem_hl` is low for every other opcode, including 0x76.
- R10: `ins_valid` rises for one cycle, in the cycle after the edge that captured the instruction's last byte. All `ins_*` fields hold their values until the next strobe. With no wait states, a three-byte instruction completes three cycles after the opcode is first requested.
- R11: After an instruction completes, the next opcode is requested at the instruction's address plus its length. `ins_addr` is the opcode's address. The counter wraps modulo 2^`AW`.
- R12: A high `pc_load` at an edge sets the next request address to `pc_load_addr`. It abandons any partly fetched instruction, so that instruction never raises `ins_valid`. The load wins over a byte capture at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_load | input | 1 | Replace the program counter |
| pc_load_addr | input | AW | New program counter value |
| mem_req | output | 1 | Program memory read request |
| mem_addr | output | AW | Program memory byte address |
| mem_rdata | input | 8 | Program memory read data |
| mem_ready | input | 1 | Read data valid this cycle |
| ins_valid | output | 1 | One-cycle strobe: instruction complete |
| ins_addr | output | AW | Address of the opcode byte |
| ins_opcode | output | 8 | Opcode byte |
| ins_len | output | 2 | Instruction length in bytes |
| ins_dst | output | 3 | Destination register code |
| ins_src | output | 3 | Source register code |
| ins_pair | output | 2 | Register pair code |
| ins_cond | output | 3 | Condition code |
| ins_psw | output | 1 | Pair 3 means accumulator-and-flags |
| ins_mem_hl | output | 1 | Operand is memory addressed by HL |
| ins_halt | output | 1 | Halt opcode |
| ins_imm8 | output | 8 | First operand byte |
| ins_imm16 | output | 16 | Operands, low byte first |

## Verification
Errors in internal state show at the ports in different ways:
- **Stored length.** A wrong stored length makes the request address at the strobe wrong at once. On the following fetch it also becomes a wrong opcode, so every opcode is placed in its own window and the next address is compared at the strobe.
- **Sequencer state.** A sequencer stuck in an operand state, or one that ignores a load, shows within a few cycles as a strobe carrying the wrong opcode or address.
- **Staging registers.** A staging register that is not cleared leaks stale operand bytes into short instructions, which shows on the immediate outputs.

All 256 opcodes are swept twice, once with no wait states and once with a pseudo-random ready pattern.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_OPC = 2'd0,
    ST_LO  = 2'd1,
    ST_HI  = 2'd2
  } fstate_e;

  typedef struct packed {
    logic [1:0] len;
    logic [2:0] dst;
    logic [2:0] src;
    logic [1:0] pair;
    logic [2:0] cond;
    logic       psw;
    logic       memhl;
    logic       halt;
  } opinfo_t;

endpackage

// File: rtl/opfetch_decode.sv
module opfetch_decode
  import opfetch_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  output opinfo_t           info
);

  logic [1:0] grp;
  logic       is_three;
  logic       is_two;
  logic       halt;
  logic       mov_mem;
  logic       alu_mem;
  logic       unary_mem;

  assign grp = op[7:6];

  always_comb begin
    is_three = 1'b0;
    is_two   = 1'b0;
    // three-byte group: pair immediates, direct addressing, jumps and calls
    if (grp == 2'b00 && op[3:0] == 4'h1) is_three = 1'b1;
    if (op == 8'h22 || op == 8'h2A || op == 8'h32 || op == 8'h3A) is_three = 1'b1;
    if (op == 8'hC3 || op == 8'hCB) is_three = 1'b1;
    if (grp == 2'b11 && op[3:0] == 4'hD) is_three = 1'b1;
    if (grp == 2'b11 && (op[2:0] == 3'b010 || op[2:0] == 3'b100)) is_three = 1'b1;
    // two-byte group: byte immediates and port access
    if ((grp == 2'b00 || grp == 2'b11) && op[2:0] == 3'b110) is_two = 1'b1;
    if (op == 8'hD3 || op == 8'hDB) is_two = 1'b1;
  end

  assign halt      = (op == 8'h76);
  assign mov_mem   = (grp == 2'b01) && (op[5:3] == 3'b110 || op[2:0] == 3'b110) && !halt;
  assign alu_mem   = (grp == 2'b10) && (op[2:0] == 3'b110);
  assign unary_mem = (op == 8'h34 || op == 8'h35 || op == 8'h36);

  always_comb begin
    info.len   = is_three ? 2'd3 : (is_two ? 2'd2 : 2'd1);
    info.dst   = op[5:3];
    info.src   = op[2:0];
    info.pair  = op[5:4];
    info.cond  = op[5:3];
    info.psw   = (grp == 2'b11) && (op[5:4] == 2'b11) &&
                 (op[3:0] == 4'h1 || op[3:0] == 4'h5);
    info.memhl = mov_mem || alu_mem || unary_mem;
    info.halt  = halt;
  end

endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
  import opfetch_pkg::*;
#(
  parameter int            AW       = 16,
  parameter logic [AW-1:0] RESET_PC = '0
)
(
  input  logic          clk,
  input  logic          rst,
  input  logic          pc_load,
  input  logic [AW-1:0] pc_load_addr,
  input  logic          mem_ready,
  input  logic [1:0]    opc_len,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          cap_opc,
  output logic          cap_lo,
  output logic          cap_hi,
  output logic          fin
);

  fstate_e       st;
  logic          req_q;
  logic [AW-1:0] pc;
  logic [1:0]    len_q;
  logic          take;

  assign take    = req_q && mem_ready && !pc_load;
  assign cap_opc = take && (st == ST_OPC);
  assign cap_lo  = take && (st == ST_LO);
  assign cap_hi  = take && (st == ST_HI);
  assign fin     = (cap_opc && opc_len == 2'd1) || (cap_lo && len_q == 2'd2) || cap_hi;

  assign mem_req  = req_q;
  assign mem_addr = pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_OPC;
      req_q <= 1'b0;
      pc    <= RESET_PC;
      len_q <= 2'd1;
    end else begin
      req_q <= 1'b1;
      if (pc_load) begin
        pc <= pc_load_addr;
        st <= ST_OPC;
      end else if (take) begin
        pc <= pc + 1'b1;
        if (cap_opc) len_q <= opc_len;
        if (fin)                st <= ST_OPC;
        else if (st == ST_OPC)  st <= ST_LO;
        else                    st <= ST_HI;
      end
    end
  end

  // R2: a stalled request keeps its address
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready && !pc_load) |=> (mem_req && $stable(mem_addr)));

  // R11: each accepted byte moves the counter on by one, wrapping
  p_step_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready && !pc_load) |=> (mem_addr == $past(mem_addr) + 1'b1));

  // R12: a load redirects the next request and restarts at an opcode
  p_load_r12: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> (mem_addr == $past(pc_load_addr) && st == ST_OPC));

  // R1: reset drops the request
  p_reset_r1: assert property (@(posedge clk) rst |=> !mem_req);

endmodule

// File: rtl/opfetch_hold.sv
module opfetch_hold
  import opfetch_pkg::*;
#(
  parameter int AW = 16
)
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_opc,
  input  logic              cap_lo,
  input  logic              cap_hi,
  input  logic              fin,
  input  logic [BYTE_W-1:0] rdata,
  input  opinfo_t           dec_info,
  input  logic [AW-1:0]     cur_addr,
  output logic              q_valid,
  output logic [AW-1:0]     q_addr,
  output logic [BYTE_W-1:0] q_opc,
  output opinfo_t           q_info,
  output logic [BYTE_W-1:0] q_lo,
  output logic [BYTE_W-1:0] q_hi
);

  logic [AW-1:0]     s_addr, n_addr;
  logic [BYTE_W-1:0] s_opc, n_opc;
  opinfo_t           s_info, n_info;
  logic [BYTE_W-1:0] s_lo, n_lo;
  logic [BYTE_W-1:0] s_hi, n_hi;

  always_comb begin
    n_addr = cap_opc ? cur_addr : s_addr;
    n_opc  = cap_opc ? rdata    : s_opc;
    n_info = cap_opc ? dec_info : s_info;
    n_lo   = cap_opc ? '0 : (cap_lo ? rdata : s_lo);
    n_hi   = (cap_opc || cap_lo) ? '0 : (cap_hi ? rdata : s_hi);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_addr  <= '0;
      s_opc   <= '0;
      s_info  <= '0;
      s_lo    <= '0;
      s_hi    <= '0;
      q_valid <= 1'b0;
      q_addr  <= '0;
      q_opc   <= '0;
      q_info  <= '0;
      q_lo    <= '0;
      q_hi    <= '0;
    end else begin
      s_addr  <= n_addr;
      s_opc   <= n_opc;
      s_info  <= n_info;
      s_lo    <= n_lo;
      s_hi    <= n_hi;
      q_valid <= fin;
      if (fin) begin
        q_addr <= n_addr;
        q_opc  <= n_opc;
        q_info <= n_info;
        q_lo   <= n_lo;
        q_hi   <= n_hi;
      end
    end
  end

  // R5: a completed instruction never reports length zero
  p_len_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    q_valid |-> (q_info.len != 2'd0));

  // R6: bytes beyond the length read as zero
  p_imm_short_r6: assert property (@(posedge clk) disable iff (rst)
    (q_valid && q_info.len != 2'd3) |-> (q_hi == '0 && (q_info.len == 2'd2 || q_lo == '0)));

  // R9: halt is never a memory operand form
  p_halt_nomem_r9: assert property (@(posedge clk) disable iff (rst)
    (q_valid && q_info.halt) |-> !q_info.memhl);

  // R10: outputs stay put between strobes
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!fin && !q_valid) |=> ($stable(q_opc) && $stable(q_lo) && $stable(q_hi)));

endmodule

// File: rtl/opfetch_unit.sv
module opfetch_unit
  import opfetch_pkg::*;
#(
  parameter int            AW       = 16,
  parameter logic [AW-1:0] RESET_PC = '0
)
(
  input  logic          clk,
  input  logic          rst,
  input  logic          pc_load,
  input  logic [AW-1:0] pc_load_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ready,
  output logic          ins_valid,
  output logic [AW-1:0] ins_addr,
  output logic [7:0]    ins_opcode,
  output logic [1:0]    ins_len,
  output logic [2:0]    ins_dst,
  output logic [2:0]    ins_src,
  output logic [1:0]    ins_pair,
  output logic [2:0]    ins_cond,
  output logic          ins_psw,
  output logic          ins_mem_hl,
  output logic          ins_halt,
  output logic [7:0]    ins_imm8,
  output logic [15:0]   ins_imm16
);

  opinfo_t           dec_info;
  opinfo_t           q_info;
  logic              cap_opc, cap_lo, cap_hi, fin;
  logic [BYTE_W-1:0] q_lo, q_hi;

  opfetch_decode u_dec (
    .op   (mem_rdata),
    .info (dec_info)
  );

  opfetch_seq #(.AW(AW), .RESET_PC(RESET_PC)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .pc_load      (pc_load),
    .pc_load_addr (pc_load_addr),
    .mem_ready    (mem_ready),
    .opc_len      (dec_info.len),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .cap_opc      (cap_opc),
    .cap_lo       (cap_lo),
    .cap_hi       (cap_hi),
    .fin          (fin)
  );

  opfetch_hold #(.AW(AW)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .cap_opc  (cap_opc),
    .cap_lo   (cap_lo),
    .cap_hi   (cap_hi),
    .fin      (fin),
    .rdata    (mem_rdata),
    .dec_info (dec_info),
    .cur_addr (mem_addr),
    .q_valid  (ins_valid),
    .q_addr   (ins_addr),
    .q_opc    (ins_opcode),
    .q_info   (q_info),
    .q_lo     (q_lo),
    .q_hi     (q_hi)
  );

  assign ins_len    = q_info.len;
  assign ins_dst    = q_info.dst;
  assign ins_src    = q_info.src;
  assign ins_pair   = q_info.pair;
  assign ins_cond   = q_info.cond;
  assign ins_psw    = q_info.psw;
  assign ins_mem_hl = q_info.memhl;
  assign ins_halt   = q_info.halt;
  assign ins_imm8   = q_lo;
  assign ins_imm16  = {q_hi, q_lo};

  // R10: a strobe always follows an accepted memory byte
  p_valid_after_byte_r10: assert property (@(posedge clk) disable iff (rst)
    ins_valid |-> $past(mem_req && mem_ready));

  // R7: reported fields match the reported opcode
  p_fields_r7: assert property (@(posedge clk) disable iff (rst)
    ins_valid |-> (ins_cond == ins_opcode[5:3] && ins_src == ins_opcode[2:0] &&
                   ins_pair == ins_opcode[5:4]));

endmodule

// File: tb/opfetch_unit_test.sv
`timescale 1ns/1ps
module opfetch_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pc_load = 1'b0;
  logic [15:0] pc_load_addr = '0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        mem_ready;
  logic        ins_valid;
  logic [15:0] ins_addr;
  logic [7:0]  ins_opcode;
  logic [1:0]  ins_len;
  logic [2:0]  ins_dst, ins_src, ins_cond;
  logic [1:0]  ins_pair;
  logic        ins_psw, ins_mem_hl, ins_halt;
  logic [7:0]  ins_imm8;
  logic [15:0] ins_imm16;

  logic [7:0]  bmem [0:1023];
  logic        force_low = 1'b0;
  logic        stall_mode = 1'b0;
  logic [7:0]  lfsr = 8'h5B;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;

  always #2 clk = ~clk;

  assign mem_rdata = bmem[mem_addr[9:0]];
  assign mem_ready = !force_low && (!stall_mode || lfsr[0] || lfsr[2]);

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cyc  <= cyc + 1;
    if (cyc > 120000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  opfetch_unit uut (
    .clk(clk), .rst(rst), .pc_load(pc_load), .pc_load_addr(pc_load_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_opcode(ins_opcode), .ins_len(ins_len),
    .ins_dst(ins_dst), .ins_src(ins_src), .ins_pair(ins_pair), .ins_cond(ins_cond),
    .ins_psw(ins_psw), .ins_mem_hl(ins_mem_hl), .ins_halt(ins_halt),
    .ins_imm8(ins_imm8), .ins_imm16(ins_imm16)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_len(input logic [7:0] op);
    casez (op)
      8'b00??0001, 8'h22, 8'h2A, 8'h32, 8'h3A, 8'hC3, 8'hCB,
      8'b11??1101, 8'b11???010, 8'b11???100: return 2'd3;
      8'b00???110, 8'b11???110, 8'hD3, 8'hDB: return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  function automatic logic exp_memhl(input logic [7:0] op);
    casez (op)
      8'h76:       return 1'b0;
      8'b01110???: return 1'b1;
      8'b01???110: return 1'b1;
      8'b10???110: return 1'b1;
      8'h34, 8'h35, 8'h36: return 1'b1;
      default:     return 1'b0;
    endcase
  endfunction

  task automatic do_load(input logic [15:0] a);
    @(negedge clk);
    pc_load = 1'b1;
    pc_load_addr = a;
    @(negedge clk);
    pc_load = 1'b0;
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    while (!ins_valid && n < 80) begin
      @(negedge clk);
      n++;
    end
    if (!ins_valid) chk("R10 strobe timeout", 32'd0, 32'd1);
  endtask

  task automatic run_op(input logic [7:0] op, input logic [15:0] base);
    logic [7:0]  lo, hi;
    logic [1:0]  len;
    logic [15:0] e16;
    int n;
    lo  = op ^ 8'hA5;
    hi  = op + 8'h3C;
    len = exp_len(op);
    bmem[base[9:0]]         = op;
    bmem[10'(base[9:0] + 1)] = lo;
    bmem[10'(base[9:0] + 2)] = hi;
    do_load(base);
    wait_valid(n);
    if (!stall_mode) chk("R10 latency", 32'(n), 32'(len));
    chk("R12 opcode after load", 32'(ins_opcode), 32'(op));
    if (len == 2'd3)      chk("R3 length", 32'(ins_len), 32'd3);
    else if (len == 2'd2) chk("R4 length", 32'(ins_len), 32'd2);
    else                  chk("R5 length", 32'(ins_len), 32'd1);
    e16 = (len == 2'd3) ? {hi, lo} : (len == 2'd2) ? {8'h00, lo} : 16'h0000;
    chk("R6 imm8", 32'(ins_imm8), (len == 2'd1) ? 32'd0 : 32'(lo));
    chk("R6 imm16", 32'(ins_imm16), 32'(e16));
    chk("R7 fields", {20'd0, ins_dst, ins_src, ins_pair, ins_cond, 1'b0},
        {20'd0, op[5:3], op[2:0], op[5:4], op[5:3], 1'b0});
    chk("R8 psw", 32'(ins_psw), 32'(op == 8'hF1 || op == 8'hF5));
    chk("R9 memhl", 32'(ins_mem_hl), 32'(exp_memhl(op)));
    chk("R9 halt", 32'(ins_halt), 32'(op == 8'h76));
    chk("R11 ins_addr", 32'(ins_addr), 32'(base));
    chk("R11 next addr", 32'(mem_addr), 32'(base + 16'(len)));
    force_low = 1'b1;
    @(negedge clk);
    chk("R10 one-cycle strobe", 32'(ins_valid), 32'd0);
    chk("R10 outputs held", {16'd0, ins_opcode, ins_imm8}, {16'd0, op, (len == 2'd1) ? 8'd0 : lo});
    force_low = 1'b0;
  endtask

  initial begin
    int n;
    for (int i = 0; i < 1024; i++) bmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset req", 32'(mem_req), 32'd0);
    chk("R1 reset addr", 32'(mem_addr), 32'd0);
    chk("R1 reset valid", 32'(ins_valid), 32'd0);
    chk("R1 reset fields", {8'd0, ins_opcode, ins_imm16}, 32'd0);
    force_low = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 req after reset", 32'(mem_req), 32'd1);
    chk("R1 addr after reset", 32'(mem_addr), 32'd0);
    force_low = 1'b0;

    for (int p = 0; p < 2; p++) begin
      stall_mode = (p == 1);
      for (int k = 0; k < 256; k++)
        run_op(8'(k), (p == 0) ? 16'(k * 4) : 16'h8000 + 16'(k * 4));
    end
    stall_mode = 1'b0;

    // R2: stall with ready low keeps the request and address
    bmem[10'h300] = 8'h76;
    bmem[10'h200] = 8'hC3; bmem[10'h201] = 8'h11; bmem[10'h202] = 8'h22;
    do_load(16'h0300);
    force_low = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R2 req held", 32'(mem_req), 32'd1);
      chk("R2 addr held", 32'(mem_addr), 32'h0300);
      chk("R2 no strobe while stalled", 32'(ins_valid), 32'd0);
    end
    force_low = 1'b0;
    wait_valid(n);
    chk("R2 opcode after stall", 32'(ins_opcode), 32'h76);

    // R12: load mid-instruction abandons it
    do_load(16'h0200);
    @(negedge clk);
    pc_load = 1'b1; pc_load_addr = 16'h0300;
    @(negedge clk);
    pc_load = 1'b0;
    wait_valid(n);
    chk("R12 abandoned instruction", 32'(ins_opcode), 32'h76);
    chk("R12 new address", 32'(ins_addr), 32'h0300);

    // R12: load wins over capture at the same edge
    @(negedge clk);
    pc_load = 1'b1; pc_load_addr = 16'h0300;
    @(negedge clk);
    pc_load_addr = 16'h0200;
    @(negedge clk);
    pc_load = 1'b0;
    chk("R12 no strobe across loads", 32'(ins_valid), 32'd0);
    wait_valid(n);
    chk("R12 load beats capture", 32'(ins_opcode), 32'hC3);
    chk("R12 load beats capture addr", 32'(ins_addr), 32'h0200);

    // R11: wrap past the top of the address space
    bmem[10'h3FE] = 8'hC3; bmem[10'h3FF] = 8'h34; bmem[10'h000] = 8'h12;
    do_load(16'hFFFE);
    wait_valid(n);
    chk("R11 wrap imm16", 32'(ins_imm16), 32'h1234);
    chk("R11 wrap next addr", 32'(mem_addr), 32'h0001);
    chk("R11 wrap ins_addr", 32'(ins_addr), 32'hFFFE);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule